// File: doc/BRIEF.md
# Three-Wide Register Rename Stage

This block renames up to three instructions in a single clock cycle. Each slot of the group names one architectural destination and two architectural sources. The block translates them into physical register tags by means of an architectural-to-physical map table. It gives every renaming slot a fresh physical register, taken from a free-register queue. For each destination it also reports the mapping that the new one displaces, so that later stages can release that register.

Instructions in one group may depend on each other. Equality comparators check every slot's destination against the sources and destination of every younger slot. When a younger source matches an older destination, the older slot's newly taken register is forwarded to it instead of the table value. When several slots write the same architectural register, only the youngest of them updates the table. The group enters through a valid/ready handshake, and the results appear combinationally in the same cycle. A group is accepted only when `grp_valid` and `grp_ready` are both high. `grp_ready` does not depend on `grp_valid`. It is high when the consumer asserts `res_ready` and the queue holds enough free registers for the group. `res_valid` shows that the results on the output pins belong to a group that can be accepted. The results are consumed in the same handshake.

Top module: `rename_group`

## Requirements
- R1: After reset, every architectural register maps to the physical register with the same number. The free queue hands out physical registers 32 to 63 in ascending order, and `grp_ready` is high whenever `res_ready` is high.
- R2: Each producing slot, meaning a valid slot whose destination is not hard-wired register zero, receives the next free-queue entry on `p_dst`. Slots are served in order, slot 0 first. A producing slot receives a tag different from every other producing slot, and the queue shrinks by the number of producing slots.
- R3: A source with no matching older producing slot in the group reads its physical tag from the map table.
- R4: A source that equals the destination of an older producing slot in the same group receives that slot's new `p_dst` tag.
- R5: When a slot 2 source matches the destinations of both slot 0 and slot 1, it receives slot 1's new tag.
- R6: `p_old` of a producing slot equals the new tag of the nearest older producing slot with the same destination. When no such slot exists, it equals the table entry.
- R7: When several producing slots of an accepted group share a destination, the table afterwards holds the youngest slot's tag. The next group's reads show this.
- R8: An invalid slot takes no free register and writes nothing to the table. It is never a forwarding source. Its `p_dst` and `p_old` read 0.
- R9: When the queue holds fewer entries than the group has producing slots, `grp_ready` and `res_valid` are low, and neither the table nor the queue changes. A group whose count of producing slots exactly equals the queue occupancy is accepted.
- R10: With the hard-wired option on (the default), a destination of register 0 neither renames nor forwards. A source of register 0 always reads physical tag 0.
- R11: When `res_ready` is low or `grp_valid` is low, no handshake happens and neither the table nor the queue changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | 1 | A group is offered |
| grp_ready | output | 1 | The block can accept a group this cycle |
| slot_vld | input | 3 | Per-slot valid, bit k for slot k (slot 0 oldest) |
| dst_a | input | 15 | Architectural destinations, slot k at bits 5k+4..5k |
| s1_a | input | 15 | First architectural sources, same packing |
| s2_a | input | 15 | Second architectural sources, same packing |
| res_valid | output | 1 | Renamed results are on the output pins |
| res_ready | input | 1 | The consumer takes the results |
| p_s1 | output | 18 | Physical first sources, slot k at bits 6k+5..6k |
| p_s2 | output | 18 | Physical second sources, same packing |
| p_dst | output | 18 | Newly taken physical destinations, same packing |
| p_old | output | 18 | Displaced previous mappings, same packing |

## Verification
Within one cycle, the block may have to forward a new tag to a younger source and also suppress an older slot's table write. This happens when a group repeats a destination that a later slot also reads. The bench provokes it with groups such as two writers of one register followed by a reader of it. It then sends a following group that reads the same register. Every output is judged against a model that renames the slots one after another, each slot reading the map as the previous slots left it. Stalls from a short queue, which can coincide with consumer back-pressure, are provoked by draining the queue with full groups.

// File: rtl/rn_pkg.sv
package rn_pkg;

  // Number of set bits in a mask of up to 32 slots.
  function automatic int count_set(input logic [31:0] m);
    int n;
    n = 0;
    for (int k = 0; k < 32; k++) n += int'(m[k]);
    return n;
  endfunction

endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 64,
  parameter int GROUP    = 3,
  localparam int PREG_W  = $clog2(NUM_PHYS),
  localparam int DEPTH   = NUM_PHYS - NUM_ARCH,
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take_en,
  input  logic [GROUP-1:0]        take_mask,
  output logic [CNT_W-1:0]        avail_cnt,
  output logic [GROUP*PREG_W-1:0] tags
);
  import rn_pkg::*;

  logic [PREG_W-1:0] ring [DEPTH];
  logic [IDX_W-1:0]  head;
  logic [CNT_W-1:0]  cnt;
  int                take_n;

  function automatic logic [IDX_W-1:0] wrap(input int base, input int off);
    int s;
    s = base + off;
    if (s >= DEPTH) s -= DEPTH;
    return IDX_W'(s);
  endfunction

  assign avail_cnt = cnt;

  always_comb take_n = count_set(32'(take_mask));

  // Each requesting slot reads the entry offset by the requesters ahead of it.
  for (genvar g = 0; g < GROUP; g++) begin : g_peek
    int off;
    always_comb begin
      off = 0;
      for (int k = 0; k < g; k++) off += int'(take_mask[k]);
      tags[g*PREG_W +: PREG_W] = ring[wrap(int'(head), off)];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      cnt  <= CNT_W'(DEPTH);
      for (int k = 0; k < DEPTH; k++) ring[k] <= PREG_W'(NUM_ARCH + k);
    end else if (take_en) begin
      head <= wrap(int'(head), take_n);
      cnt  <= cnt - CNT_W'(take_n);
    end
  end

endmodule

// File: rtl/rn_alias_table.sv
module rn_alias_table #(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 64,
  parameter int GROUP    = 3,
  parameter int RD_PORTS = 3 * GROUP,
  localparam int AREG_W  = $clog2(NUM_ARCH),
  localparam int PREG_W  = $clog2(NUM_PHYS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [RD_PORTS*AREG_W-1:0] rd_a,
  output logic [RD_PORTS*PREG_W-1:0] rd_p,
  input  logic [GROUP-1:0]           wr_en,
  input  logic [GROUP*AREG_W-1:0]    wr_a,
  input  logic [GROUP*PREG_W-1:0]    wr_p
);

  logic [PREG_W-1:0] map [NUM_ARCH];

  for (genvar r = 0; r < RD_PORTS; r++) begin : g_rd
    assign rd_p[r*PREG_W +: PREG_W] = map[rd_a[r*AREG_W +: AREG_W]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_ARCH; k++) map[k] <= PREG_W'(k);
    end else begin
      for (int k = 0; k < GROUP; k++)
        if (wr_en[k]) map[wr_a[k*AREG_W +: AREG_W]] <= wr_p[k*PREG_W +: PREG_W];
    end
  end

endmodule

// File: rtl/rn_dep_check.sv
module rn_dep_check #(
  parameter int GROUP  = 3,
  parameter int AREG_W = 5,
  parameter int PREG_W = 6,
  parameter bit ZERO_HW = 1'b1
) (
  input  logic [GROUP-1:0]        slot_vld,
  input  logic [GROUP*AREG_W-1:0] dst_a,
  input  logic [GROUP*AREG_W-1:0] s1_a,
  input  logic [GROUP*AREG_W-1:0] s2_a,
  input  logic [GROUP*PREG_W-1:0] new_p,
  input  logic [GROUP*PREG_W-1:0] tbl_s1,
  input  logic [GROUP*PREG_W-1:0] tbl_s2,
  input  logic [GROUP*PREG_W-1:0] tbl_old,
  output logic [GROUP*PREG_W-1:0] p_s1,
  output logic [GROUP*PREG_W-1:0] p_s2,
  output logic [GROUP*PREG_W-1:0] p_dst,
  output logic [GROUP*PREG_W-1:0] p_old,
  output logic [GROUP-1:0]        prod,
  output logic [GROUP-1:0]        wr_sel
);

  logic [AREG_W-1:0] d [GROUP];
  logic [AREG_W-1:0] a [GROUP];
  logic [AREG_W-1:0] b [GROUP];
  logic [PREG_W-1:0] np [GROUP];

  for (genvar g = 0; g < GROUP; g++) begin : g_unpack
    assign d[g]    = dst_a[g*AREG_W +: AREG_W];
    assign a[g]    = s1_a[g*AREG_W +: AREG_W];
    assign b[g]    = s2_a[g*AREG_W +: AREG_W];
    assign np[g]   = new_p[g*PREG_W +: PREG_W];
    assign prod[g] = slot_vld[g] && !(ZERO_HW && (d[g] == '0));
  end

  // Per younger slot: compare with each older producer, scanning oldest
  // first so the nearest older match overrides.
  for (genvar j = 0; j < GROUP; j++) begin : g_slot
    logic [PREG_W-1:0] ps1, ps2, pold;
    logic              younger_hit;
    always_comb begin
      ps1  = tbl_s1[j*PREG_W +: PREG_W];
      ps2  = tbl_s2[j*PREG_W +: PREG_W];
      pold = tbl_old[j*PREG_W +: PREG_W];
      for (int i = 0; i < j; i++) begin
        if (prod[i] && (d[i] == a[j])) ps1  = np[i];
        if (prod[i] && (d[i] == b[j])) ps2  = np[i];
        if (prod[i] && (d[i] == d[j])) pold = np[i];
      end
      younger_hit = 1'b0;
      for (int k = j + 1; k < GROUP; k++)
        if (prod[k] && (d[k] == d[j])) younger_hit = 1'b1;
    end
    assign p_s1[j*PREG_W +: PREG_W]  = ps1;
    assign p_s2[j*PREG_W +: PREG_W]  = ps2;
    assign p_dst[j*PREG_W +: PREG_W] = prod[j] ? np[j] : '0;
    assign p_old[j*PREG_W +: PREG_W] = prod[j] ? pold : '0;
    assign wr_sel[j]                 = prod[j] && !younger_hit;
  end

endmodule

// File: rtl/rename_group.sv
module rename_group #(
  parameter int GROUP    = 3,
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 64,
  parameter bit ZERO_HW  = 1'b1,
  localparam int AREG_W  = $clog2(NUM_ARCH),
  localparam int PREG_W  = $clog2(NUM_PHYS),
  localparam int DEPTH   = NUM_PHYS - NUM_ARCH,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    grp_valid,
  output logic                    grp_ready,
  input  logic [GROUP-1:0]        slot_vld,
  input  logic [GROUP*AREG_W-1:0] dst_a,
  input  logic [GROUP*AREG_W-1:0] s1_a,
  input  logic [GROUP*AREG_W-1:0] s2_a,
  output logic                    res_valid,
  input  logic                    res_ready,
  output logic [GROUP*PREG_W-1:0] p_s1,
  output logic [GROUP*PREG_W-1:0] p_s2,
  output logic [GROUP*PREG_W-1:0] p_dst,
  output logic [GROUP*PREG_W-1:0] p_old
);
  import rn_pkg::*;

  logic [GROUP-1:0]          prod, wr_sel;
  logic [GROUP*PREG_W-1:0]   new_p;
  logic [3*GROUP*PREG_W-1:0] rd_p;
  logic [CNT_W-1:0]          avail_cnt, need_cnt;
  logic                      enough, fire;

  assign need_cnt  = CNT_W'(count_set(32'(prod)));
  assign enough    = (avail_cnt >= need_cnt);
  assign grp_ready = res_ready && enough;
  assign res_valid = grp_valid && enough;
  assign fire      = grp_valid && grp_ready;

  rn_free_list #(
    .NUM_ARCH (NUM_ARCH),
    .NUM_PHYS (NUM_PHYS),
    .GROUP    (GROUP)
  ) u_free (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_en   (fire),
    .take_mask (prod),
    .avail_cnt (avail_cnt),
    .tags      (new_p)
  );

  rn_alias_table #(
    .NUM_ARCH (NUM_ARCH),
    .NUM_PHYS (NUM_PHYS),
    .GROUP    (GROUP),
    .RD_PORTS (3 * GROUP)
  ) u_map (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_a  ({dst_a, s2_a, s1_a}),
    .rd_p  (rd_p),
    .wr_en (wr_sel & {GROUP{fire}}),
    .wr_a  (dst_a),
    .wr_p  (new_p)
  );

  rn_dep_check #(
    .GROUP   (GROUP),
    .AREG_W  (AREG_W),
    .PREG_W  (PREG_W),
    .ZERO_HW (ZERO_HW)
  ) u_dep (
    .slot_vld (slot_vld),
    .dst_a    (dst_a),
    .s1_a     (s1_a),
    .s2_a     (s2_a),
    .new_p    (new_p),
    .tbl_s1   (rd_p[0 +: GROUP*PREG_W]),
    .tbl_s2   (rd_p[GROUP*PREG_W +: GROUP*PREG_W]),
    .tbl_old  (rd_p[2*GROUP*PREG_W +: GROUP*PREG_W]),
    .p_s1     (p_s1),
    .p_s2     (p_s2),
    .p_dst    (p_dst),
    .p_old    (p_old),
    .prod     (prod),
    .wr_sel   (wr_sel)
  );

endmodule

// File: rtl/rename_group_chk.sv
module rename_group_chk #(
  parameter int GROUP  = 3,
  parameter int AREG_W = 5,
  parameter int PREG_W = 6,
  parameter int CNT_W  = 6,
  parameter bit ZERO_HW = 1'b1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    grp_valid,
  input logic                    grp_ready,
  input logic                    res_valid,
  input logic [GROUP-1:0]        slot_vld,
  input logic [GROUP*AREG_W-1:0] dst_a,
  input logic [GROUP*AREG_W-1:0] s1_a,
  input logic [GROUP*PREG_W-1:0] p_s1,
  input logic [GROUP*PREG_W-1:0] p_dst,
  input logic [CNT_W-1:0]        avail_cnt,
  input logic [CNT_W-1:0]        need_cnt
);

  a_r9_enough: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (avail_cnt >= need_cnt));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(grp_valid && grp_ready) |=> (avail_cnt == $past(avail_cnt)));

  a_r2_consume: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && grp_ready) |=> (avail_cnt == $past(avail_cnt) - $past(need_cnt)));

  for (genvar i = 0; i < GROUP; i++) begin : g_slot
    a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_vld[i] |-> (p_dst[i*PREG_W +: PREG_W] == '0));

    a_r10_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ZERO_HW && (s1_a[i*AREG_W +: AREG_W] == '0)) |-> (p_s1[i*PREG_W +: PREG_W] == '0));

    for (genvar j = i + 1; j < GROUP; j++) begin : g_pair
      a_r2_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_valid && grp_ready && slot_vld[i] && slot_vld[j]
         && (!ZERO_HW || (dst_a[i*AREG_W +: AREG_W] != '0))
         && (!ZERO_HW || (dst_a[j*AREG_W +: AREG_W] != '0)))
        |-> (p_dst[i*PREG_W +: PREG_W] != p_dst[j*PREG_W +: PREG_W]));
    end
  end

  if (GROUP >= 3) begin : g_near
    a_r5_nearest: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_vld[0] && slot_vld[1]
       && (dst_a[0 +: AREG_W] == dst_a[AREG_W +: AREG_W])
       && (dst_a[AREG_W +: AREG_W] == s1_a[2*AREG_W +: AREG_W])
       && (!ZERO_HW || (dst_a[AREG_W +: AREG_W] != '0)))
      |-> (p_s1[2*PREG_W +: PREG_W] == p_dst[PREG_W +: PREG_W]));
  end

endmodule

bind rename_group rename_group_chk #(
  .GROUP   (GROUP),
  .AREG_W  (AREG_W),
  .PREG_W  (PREG_W),
  .CNT_W   (CNT_W),
  .ZERO_HW (ZERO_HW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .grp_valid (grp_valid),
  .grp_ready (grp_ready),
  .res_valid (res_valid),
  .slot_vld  (slot_vld),
  .dst_a     (dst_a),
  .s1_a      (s1_a),
  .p_s1      (p_s1),
  .p_dst     (p_dst),
  .avail_cnt (avail_cnt),
  .need_cnt  (need_cnt)
);

// File: tb/tb_rename_group.sv
`timescale 1ns/1ps
module tb_rename_group;
  localparam int G  = 3;
  localparam int AW = 5;
  localparam int PW = 6;
  localparam int NA = 32;
  localparam int NP = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          grp_valid = 1'b0;
  logic          res_ready = 1'b0;
  logic [G-1:0]  slot_vld = '0;
  logic [G*AW-1:0] dst_a = '0, s1_a = '0, s2_a = '0;
  logic          grp_ready, res_valid;
  logic [G*PW-1:0] p_s1, p_s2, p_dst, p_old;

  always #5 clk = ~clk;

  rename_group dut (
    .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp_ready(grp_ready),
    .slot_vld(slot_vld), .dst_a(dst_a), .s1_a(s1_a), .s2_a(s2_a),
    .res_valid(res_valid), .res_ready(res_ready),
    .p_s1(p_s1), .p_s2(p_s2), .p_dst(p_dst), .p_old(p_old)
  );

  typedef struct {
    bit            rdy;
    bit            vld;
    logic [G*PW-1:0] s1, s2, d, o;
    string         tag;
  } exp_t;

  exp_t sb[$];
  exp_t m;
  int   map[NA];
  int   fl[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one group and queues the result that a slot-by-slot
  // rename of the current model state predicts.
  task automatic drive(input bit gv, input bit rr, input logic [G-1:0] v,
                       input int d[G], input int a[G], input int b[G],
                       input string tag);
    exp_t e;
    int   tm[NA];
    int   np, idx;
    @(negedge clk);
    grp_valid = gv;
    res_ready = rr;
    slot_vld  = v;
    for (int k = 0; k < G; k++) begin
      dst_a[k*AW +: AW] = AW'(d[k]);
      s1_a[k*AW +: AW]  = AW'(a[k]);
      s2_a[k*AW +: AW]  = AW'(b[k]);
    end
    np = 0;
    for (int k = 0; k < G; k++) if (v[k] && d[k] != 0) np++;
    e.rdy = rr && (fl.size() >= np);
    e.vld = gv && (fl.size() >= np);
    e.tag = tag;
    e.s1 = '0; e.s2 = '0; e.d = '0; e.o = '0;
    tm = map;
    idx = 0;
    for (int k = 0; k < G; k++) begin
      e.s1[k*PW +: PW] = PW'(tm[a[k]]);
      e.s2[k*PW +: PW] = PW'(tm[b[k]]);
      if (v[k] && d[k] != 0 && idx < fl.size()) begin
        e.o[k*PW +: PW] = PW'(tm[d[k]]);
        e.d[k*PW +: PW] = PW'(fl[idx]);
        tm[d[k]] = fl[idx];
        idx++;
      end
    end
    if (gv && e.rdy) begin
      map = tm;
      for (int k = 0; k < np; k++) void'(fl.pop_front());
    end
    sb.push_back(e);
  endtask

  // Monitor: compares settled outputs well after the driving edge.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        m = sb.pop_front();
        check(m.tag, "grp_ready", 32'(grp_ready), 32'(m.rdy));
        check(m.tag, "res_valid", 32'(res_valid), 32'(m.vld));
        if (m.vld) begin
          check(m.tag, "p_s1",  32'(p_s1),  32'(m.s1));
          check(m.tag, "p_s2",  32'(p_s2),  32'(m.s2));
          check(m.tag, "p_dst", 32'(p_dst), 32'(m.d));
          check(m.tag, "p_old", 32'(p_old), 32'(m.o));
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NA; k++) map[k] = k;
    for (int k = NA; k < NP; k++) fl.push_back(k);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: idle after reset, ready with consumer ready, nothing valid
    drive(0, 1, 3'b000, '{0,0,0}, '{0,0,0}, '{0,0,0}, "R1 reset");
    // R1 R2 R3: independent group reads identity map, takes 32,33,34
    drive(1, 1, 3'b111, '{1,2,3}, '{4,5,6}, '{7,8,9}, "R1 R2 R3 independent");
    // R4: younger sources read older slots' fresh tags
    drive(1, 1, 3'b111, '{10,11,12}, '{1,10,11}, '{2,3,10}, "R4 forward");
    // R5: slot 2 reads reg 13 written by slots 0 and 1
    drive(1, 1, 3'b111, '{13,13,14}, '{13,9,13}, '{0,13,4}, "R5 nearest");
    // R6: three writers of reg 15 chain their old mappings
    drive(1, 1, 3'b111, '{15,15,15}, '{15,15,15}, '{1,2,3}, "R6 old chain");
    // R7: following group sees only youngest writers of 13 and 15
    drive(1, 1, 3'b111, '{16,17,18}, '{15,13,14}, '{10,11,12}, "R7 youngest");
    // R8: slot 1 invalid; slot 2 reads reg 21 from the table
    drive(1, 1, 3'b101, '{20,21,22}, '{5,20,21}, '{6,7,20}, "R8 invalid slot");
    drive(1, 1, 3'b111, '{23,24,25}, '{21,22,20}, '{0,1,2}, "R8 no write");
    // R10: register 0 destinations neither rename nor forward
    drive(1, 1, 3'b111, '{0,0,3}, '{0,0,0}, '{3,0,3}, "R10 zero reg");
    // R11: consumer back-pressure, then idle, then acceptance
    drive(1, 0, 3'b111, '{26,27,28}, '{26,27,28}, '{1,2,3}, "R11 back-pressure");
    drive(0, 1, 3'b111, '{26,27,28}, '{26,27,28}, '{1,2,3}, "R11 idle");
    drive(1, 1, 3'b111, '{26,27,28}, '{26,27,28}, '{1,2,3}, "R11 accept");
    // R9: drain queue with full groups until stalls appear
    for (int n = 0; n < 6; n++)
      drive(1, 1, 3'b111, '{29,30,31}, '{29,30,31}, '{1,2,3}, "R9 drain");
    // R9: exact fit with two producers, then single-slot stalls
    drive(1, 1, 3'b011, '{4,5,0}, '{4,5,6}, '{7,8,9}, "R9 exact fit");
    drive(1, 1, 3'b001, '{6,0,0}, '{6,4,5}, '{0,0,0}, "R9 empty stall");
    drive(1, 0, 3'b001, '{6,0,0}, '{6,4,5}, '{0,0,0}, "R9 R11 stall and back-pressure");
    // R8 R10: groups without producers still pass on an empty queue
    drive(1, 1, 3'b000, '{7,8,9}, '{4,5,6}, '{1,2,3}, "R8 no producers");
    drive(1, 1, 3'b111, '{0,0,0}, '{0,4,5}, '{6,0,29}, "R10 zero on empty");
    drive(0, 1, 3'b000, '{0,0,0}, '{0,0,0}, '{0,0,0}, "R11 final idle");

    @(negedge clk);
    #5;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule